// File: doc/BRIEF.md
# Device operation mode controller

This block keeps the device's eight-bit operation control register and turns its fields into the signals that govern the rest of the device. A two-bit mode field selects Standby, Active or Speed operation. The outputs that follow from it are an event-enable, a reply mute, a one-cycle register dump request, a status LED whose blink rate shows the mode, and a heartbeat strobe issued once per second. Message framing and the Speed protocol are handled elsewhere.

The block has no clock of its own for seconds. An external one-cycle tick marks each elapsed second. A host-activity pulse reports every healthy exchange with the host. If three second ticks pass with no activity, the block drops to Standby and pulses a transmit-buffer flush. A critical-error input latches a fast blink that only a reset clears. LED timing comes from an internal prescaler that produces a 50 ms step, sized by the parameter `TICK_CYCLES`.

Top module: `opmode_ctrl`

## Requirements
- R1: The mode field is bits [1:0] of the control register: 0 = Standby, 1 = Active, 2 = reserved, 3 = Speed. A write whose bits [1:0] equal 2 leaves the mode unchanged and still updates the other fields.
- R2: `event_en_o` is high exactly while the mode is Active (1), and low in Standby and Speed.
- R3: A write with bit 3 set raises `dump_req_o` for exactly one cycle, in the cycle after the write. Bits 3 and 2 always read back as 0.
- R4: `reply_mute_o` follows control bit 4.
- R5: While control bit 5 (visual enable) is 0, `led_o` stays low.
- R6: With bits 5 and 6 set and no error latched, `led_o` changes state every 2 s in Standby, every 1 s in Active and every 0.5 s in Speed, giving periods of 4, 2 and 1 s. Each half-period is a multiple of 50 ms steps of `TICK_CYCLES` clocks each.
- R7: A pulse on `crit_err_i` latches an error state that only reset clears. While it is latched and bit 5 is set, `led_o` changes state every 50 ms (period 0.1 s), whatever the mode and bit 6.
- R8: When bit 7 is set and the mode is Active, each `sec_tick_i` produces a one-cycle `heartbeat_o` in the following cycle. No strobe is produced otherwise.
- R9: When `SILENCE_SECS` (default 3) consecutive second ticks arrive without a `host_act_i` pulse, the mode becomes Standby and `tx_flush_o` pulses for one cycle after the last of those ticks. A `host_act_i` pulse restarts the count, and wins over a tick in the same cycle.
- R10: After reset the register reads 0xE0: bits 7, 6 and 5 are set, mute is off and the mode is Standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the control register |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Current register contents |
| sec_tick_i | input | 1 | One-cycle pulse per elapsed second |
| host_act_i | input | 1 | Pulse per healthy host exchange |
| crit_err_i | input | 1 | Critical error indication |
| event_en_o | output | 1 | Events may be emitted |
| reply_mute_o | output | 1 | Suppress command replies |
| dump_req_o | output | 1 | One-cycle request to queue all registers |
| tx_flush_o | output | 1 | One-cycle transmit-buffer flush |
| led_o | output | 1 | Status LED drive |
| heartbeat_o | output | 1 | One-cycle heartbeat request |

## Verification
The hardest state to reach from the ports is the silence timeout. It needs exactly `SILENCE_SECS` second ticks with no host activity, while the register holds a mode other than Standby. The bench sets Active mode and clears the count with an activity pulse. It then gives the ticks one at a time, checking that nothing fires early, and checks the mode and the flush after the last tick. A second run puts an activity pulse between the ticks. The LED rates use a prescaler scaled down to four clocks per step, so every blink period, including the latched-error rate, is measured in clock cycles between LED transitions.

// File: rtl/opmode_pkg.sv
// Shared types and timing constants for the operation mode controller.
package opmode_pkg;

    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_ACTIVE  = 2'd1,
        MODE_RSVD    = 2'd2,
        MODE_SPEED   = 2'd3
    } opmode_e;

    // LED half-periods counted in 50 ms steps
    localparam int HALF_STANDBY = 40;
    localparam int HALF_ACTIVE  = 20;
    localparam int HALF_SPEED   = 10;
    localparam int HALF_ERROR   = 1;
    localparam int HALF_W       = $clog2(HALF_STANDBY + 1);

    localparam logic [7:0] CTRL_RESET = 8'hE0;

endpackage

// File: rtl/opmode_watchdog.sv
// Host-silence watchdog.
// Counts second ticks since the last host activity pulse. It raises
// timeout_o for one cycle, together with the tick that completes
// SILENCE_SECS silent seconds. Assumes ticks are single-cycle pulses.
module opmode_watchdog #(
    parameter int SILENCE_SECS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick_i,
    input  logic host_act_i,
    output logic timeout_o
);
    localparam int CW = $clog2(SILENCE_SECS + 1);
    localparam logic [CW-1:0] LAST = CW'(SILENCE_SECS - 1);

    logic [CW-1:0] silent_q;

    // Count silent seconds; activity restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            silent_q <= '0;
        end else if (host_act_i) begin
            silent_q <= '0;
        end else if (sec_tick_i) begin
            silent_q <= (silent_q == LAST) ? '0 : silent_q + 1'b1;
        end
    end

    assign timeout_o = sec_tick_i && !host_act_i && (silent_q == LAST);

    // R9
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_act_i |=> (silent_q == '0));

endmodule

// File: rtl/opmode_blinker.sv
// LED blink generator.
// A prescaler produces a 50 ms step every TICK_CYCLES clocks. The blink
// output toggles after a number of steps chosen by the mode, or by the
// error flag, which takes precedence. Assumes TICK_CYCLES >= 2.
module opmode_blinker
    import opmode_pkg::*;
#(
    parameter int TICK_CYCLES = 5_000_000
) (
    input  logic    clk,
    input  logic    rst_n,
    input  opmode_e mode_i,
    input  logic    err_i,
    output logic    blink_o
);
    localparam int PW = $clog2(TICK_CYCLES);
    localparam logic [PW-1:0] PRE_LAST = PW'(TICK_CYCLES - 1);

    logic [PW-1:0]     pre_q;
    logic [HALF_W-1:0] half_q;
    logic [HALF_W-1:0] limit;
    logic              step;
    logic              blink_q;

    // Prescaler producing one step per 50 ms.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
    end

    assign step = (pre_q == PRE_LAST);

    // Half-period selection: error first, then mode.
    always_comb begin
        if (err_i) begin
            limit = HALF_W'(HALF_ERROR);
        end else begin
            unique case (mode_i)
                MODE_ACTIVE: limit = HALF_W'(HALF_ACTIVE);
                MODE_SPEED:  limit = HALF_W'(HALF_SPEED);
                default:     limit = HALF_W'(HALF_STANDBY);
            endcase
        end
    end

    // Step counter and toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q  <= '0;
            blink_q <= 1'b0;
        end else if (step) begin
            if (half_q >= limit - 1'b1) begin
                half_q  <= '0;
                blink_q <= ~blink_q;
            end else begin
                half_q <= half_q + 1'b1;
            end
        end
    end

    assign blink_o = blink_q;

    // R6
    toggle_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(blink_q) |-> $past(step));

endmodule

// File: rtl/opmode_beat.sv
// Heartbeat generator.
// Registers a one-cycle strobe after each second tick while enabled.
module opmode_beat (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick_i,
    input  logic enable_i,
    output logic beat_o
);
    logic beat_q;

    // One strobe per enabled second tick.
    always_ff @(posedge clk) begin
        if (!rst_n) beat_q <= 1'b0;
        else        beat_q <= sec_tick_i && enable_i;
    end

    assign beat_o = beat_q;

    // R8
    beat_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_q |-> $past(sec_tick_i));

endmodule

// File: rtl/opmode_ctrl.sv
// Operation mode controller top.
// Holds the control register: mode field, dump trigger, mute, visual
// enable, LED-mode enable and heartbeat enable. It derives event gating,
// the LED, the heartbeat and the silence fallback from it. Assumes
// sec_tick_i and host_act_i are single-cycle pulses in the clk domain.
module opmode_ctrl
    import opmode_pkg::*;
#(
    parameter int TICK_CYCLES  = 5_000_000,
    parameter int SILENCE_SECS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] rd_data_o,
    input  logic       sec_tick_i,
    input  logic       host_act_i,
    input  logic       crit_err_i,
    output logic       event_en_o,
    output logic       reply_mute_o,
    output logic       dump_req_o,
    output logic       tx_flush_o,
    output logic       led_o,
    output logic       heartbeat_o
);
    opmode_e mode_q;
    logic    alive_q, opled_q, visual_q, mute_q;
    logic    dump_q, flush_q, err_q;
    logic    timeout, blink;

    opmode_watchdog #(.SILENCE_SECS(SILENCE_SECS)) u_wdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_tick_i (sec_tick_i),
        .host_act_i (host_act_i),
        .timeout_o  (timeout)
    );

    opmode_blinker #(.TICK_CYCLES(TICK_CYCLES)) u_blink (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_q),
        .err_i   (err_q),
        .blink_o (blink)
    );

    opmode_beat u_beat (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_tick_i (sec_tick_i),
        .enable_i   (alive_q && (mode_q == MODE_ACTIVE)),
        .beat_o     (heartbeat_o)
    );

    // Control register write; the silence timeout overrides the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alive_q  <= CTRL_RESET[7];
            opled_q  <= CTRL_RESET[6];
            visual_q <= CTRL_RESET[5];
            mute_q   <= CTRL_RESET[4];
            mode_q   <= MODE_STANDBY;
        end else begin
            if (wr_en_i) begin
                alive_q  <= wr_data_i[7];
                opled_q  <= wr_data_i[6];
                visual_q <= wr_data_i[5];
                mute_q   <= wr_data_i[4];
                if (wr_data_i[1:0] != MODE_RSVD) mode_q <= opmode_e'(wr_data_i[1:0]);
            end
            if (timeout) mode_q <= MODE_STANDBY;
        end
    end

    // Single-cycle dump and flush pulses, sticky error latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dump_q  <= 1'b0;
            flush_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            dump_q  <= wr_en_i && wr_data_i[3];
            flush_q <= timeout;
            err_q   <= err_q || crit_err_i;
        end
    end

    assign rd_data_o    = {alive_q, opled_q, visual_q, mute_q, 2'b00, mode_q};
    assign event_en_o   = (mode_q == MODE_ACTIVE);
    assign reply_mute_o = mute_q;
    assign dump_req_o   = dump_q;
    assign tx_flush_o   = flush_q;
    assign led_o        = visual_q && (opled_q || err_q) && blink;

    // R1
    no_reserved_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != MODE_RSVD);

    // R3
    dump_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dump_q |-> $past(wr_en_i && wr_data_i[3]));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R9
    flush_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_q |-> (mode_q == MODE_STANDBY));

endmodule

// File: tb/opmode_ctrl_tb.sv
// Directed bench for opmode_ctrl.
module opmode_ctrl_tb;
    localparam int TC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       sec_tick = 1'b0, host_act = 1'b0, crit_err = 1'b0;
    logic       event_en, reply_mute, dump_req, tx_flush, led, heartbeat;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    opmode_ctrl #(.TICK_CYCLES(TC), .SILENCE_SECS(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd_data), .sec_tick_i(sec_tick), .host_act_i(host_act),
        .crit_err_i(crit_err), .event_en_o(event_en), .reply_mute_o(reply_mute),
        .dump_req_o(dump_req), .tx_flush_o(tx_flush), .led_o(led),
        .heartbeat_o(heartbeat)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic activity();
        @(negedge clk); host_act = 1'b1;
        @(negedge clk); host_act = 1'b0;
    endtask

    // Wait for an LED transition; returns cycle of change or -1.
    task automatic wait_led_edge(output int when);
        logic prev;
        prev = led;
        when = -1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (led != prev) begin
                when = cyc;
                break;
            end
        end
    endtask

    task automatic measure_half(input string req, input int exp_cycles);
        int t0, t1, t2;
        wait_led_edge(t0);
        wait_led_edge(t1);
        wait_led_edge(t2);
        check(req, (t1 < 0 || t2 < 0) ? -1 : t2 - t1, exp_cycles);
    endtask

    task automatic t_reset();
        check("R10 reset value", rd_data, 8'hE0);
        check("R2 events off in Standby", event_en, 0);
        check("R4 mute off at reset", reply_mute, 0);
    endtask

    task automatic t_register();
        write_reg(8'hE1);
        check("R2 events on in Active", event_en, 1);
        write_reg(8'hE2);
        check("R1 reserved mode ignored", rd_data, 8'hE1);
        write_reg(8'hE3);
        check("R2 events off in Speed", event_en, 0);
        check("R1 speed mode read", rd_data[1:0], 3);
        write_reg(8'hED);
        check("R3 dump pulse", dump_req, 1);
        check("R3 dump bit reads 0", rd_data, 8'hE1);
        @(negedge clk);
        check("R3 dump single cycle", dump_req, 0);
        write_reg(8'hF1);
        check("R4 mute on", reply_mute, 1);
        write_reg(8'hE1);
        check("R4 mute off", reply_mute, 0);
    endtask

    task automatic t_heartbeat();
        activity();
        tick();
        check("R8 heartbeat in Active", heartbeat, 1);
        @(negedge clk);
        check("R8 heartbeat single cycle", heartbeat, 0);
        write_reg(8'h61);
        activity();
        tick();
        check("R8 no heartbeat with alive off", heartbeat, 0);
        write_reg(8'hE3);
        activity();
        tick();
        check("R8 no heartbeat in Speed", heartbeat, 0);
        write_reg(8'hE1);
    endtask

    task automatic t_watchdog();
        activity();
        tick(); tick(); activity(); tick(); tick();
        check("R9 activity restarts count", rd_data[1:0], 1);
        check("R9 no flush with activity", tx_flush, 0);
        activity();
        tick(); tick();
        check("R9 no timeout before third tick", rd_data[1:0], 1);
        tick();
        check("R9 timeout forces Standby", rd_data[1:0], 0);
        check("R9 flush pulse", tx_flush, 1);
        @(negedge clk);
        check("R9 flush single cycle", tx_flush, 0);
    endtask

    task automatic t_led();
        write_reg(8'hE0);
        measure_half("R6 Standby half-period", 40 * TC);
        write_reg(8'hE1);
        measure_half("R6 Active half-period", 20 * TC);
        write_reg(8'hE3);
        measure_half("R6 Speed half-period", 10 * TC);
    endtask

    task automatic t_visual_off();
        int seen;
        write_reg(8'hC3);
        seen = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (led) seen++;
        end
        check("R5 LED held low with visual off", seen, 0);
    endtask

    task automatic t_error();
        write_reg(8'hA1);
        @(negedge clk); crit_err = 1'b1;
        @(negedge clk); crit_err = 1'b0;
        measure_half("R7 error fast blink", 1 * TC);
        write_reg(8'hE0);
        measure_half("R7 error persists after write", 1 * TC);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_register();
                t_heartbeat();
                t_watchdog();
                t_led();
                t_visual_off();
                t_error();
            end
            begin
                repeat (150000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule